// File: doc/BRIEF.md
# Compatibility Mode Lock Register

This block keeps the one-time choice between full color operation and mono-compatibility operation. It also owns the flag that keeps the boot ROM overlaid on the address map. It sits on a byte-wide I/O register bus decoded by an 8-bit offset. A bus write is one cycle with `io_wr` high. Reads are combinational from `io_addr` to `io_rdata` and have no side effects. No data stream passes through the block, so every pin is a plain control or status signal and there is no valid/ready handshake.

After reset the mode register takes the first write that reaches it and ignores every later one. Color mode stays forced on while the boot phase lasts, even when compatibility has already been chosen. A write of any value to the boot-end offset closes the boot phase and removes the boot ROM overlay. Four small scratch registers keep only the bits their masks allow. Every bit outside a mask reads back as 1.

The three configuration inputs are sampled while reset is held. They choose mono hardware, skipping the boot ROM, and whether the cartridge is a color cartridge. Together they decide how the lock is preloaded.

Top module: `cml_lock_top`

## Requirements
- R1: After a reset with all configuration inputs low, `color_mode_o` is 1, `boot_rom_on_o` is 1 and `scratch_o` is all zero.
- R2: The first write to offset 0x4C after reset selects mono-compatibility mode when data bit 2 is 1, and color mode when data bit 2 is 0.
- R3: Once the mode register holds a value, further writes to 0x4C leave the chosen mode unchanged.
- R4: `color_mode_o` is 1 when color mode is chosen or while the boot phase lasts. It is 0 only when compatibility mode is chosen and the boot phase has ended, and it only drops in the cycle after a boot-end write.
- R5: A write of any value to offset 0x50 ends the boot phase and drives `boot_rom_on_o` to 0 from the next cycle on, and the flag never returns to 1 before reset. A read of 0x50 returns 0xFF.
- R6: Scratch registers sit at offsets 0x72 to 0x75 (index 0 to 3), with masks 0xFF, 0xFF, 0xFF and 0x70. Each one stores write data AND mask and reads back as (stored AND mask) OR (NOT mask). `scratch_o` carries index i in bits [8i+7:8i].
- R7: Scratch index 2 (0x74) is reachable only while `color_mode_o` is 1. The other three are reachable only when `cfg_mono_hw` is 0. A scratch register that cannot be reached reads 0xFF and ignores writes.
- R8: A reset with `cfg_skip_boot` high ends the boot phase and clears `boot_rom_on_o`. It marks the mode register as already written, with compatibility chosen when `cfg_color_cart` is 0 or `cfg_mono_hw` is 1, and color mode chosen otherwise.
- R9: A reset with `cfg_mono_hw` high and `cfg_skip_boot` low chooses compatibility mode, marks the mode register as written and ends the boot phase, and leaves `boot_rom_on_o` at 1 until the boot-end write.
- R10: A read of offset 0x4C, or of any offset that is neither the boot-end offset nor a reachable scratch register, returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration is sampled while it is low |
| cfg_mono_hw | input | 1 | The hardware is the mono model |
| cfg_skip_boot | input | 1 | Start without running the boot ROM |
| cfg_color_cart | input | 1 | The inserted cartridge supports color |
| io_wr | input | 1 | One-cycle write strobe |
| io_addr | input | 8 | Register offset |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data for `io_addr` |
| color_mode_o | output | 1 | Color-only registers are visible |
| boot_rom_on_o | output | 1 | Boot ROM overlay is enabled |
| scratch_o | output | 32 | Stored value of each scratch register |

## Verification
The mode register is exercised with write sequences whose first value has bit 2 set in one run and clear in another. Each sequence is followed by a contrary second write and then the boot-end write. This shows whether first-write locking holds, and whether the forced color phase is kept apart from the chosen mode. Each of the four reset configurations is tried: normal boot, mono hardware with boot, skip boot with a color cartridge, and skip boot with a mono cartridge. This separates the preload paths. Each scratch register is written with all-ones, with values that touch only masked-off bits, and with mixed patterns, under both reachable and unreachable conditions. These cases tell masking on store apart from masking on read, and also catch a missing access gate.

// File: rtl/cml_pkg.sv
package cml_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SCR_N  = 4;

  localparam logic [ADDR_W-1:0] OFS_MODE     = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_BOOT_END = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_SCR_BASE = 8'h72;

  localparam int unsigned MODE_SEL_BIT = 2;

  localparam logic [SCR_N*DATA_W-1:0] SCR_MASKS = 32'h70FF_FFFF;
  localparam logic [SCR_N-1:0]        SCR_COLOR_GATED = 4'b0100;

  localparam logic [DATA_W-1:0] IDLE_READ = '1;
endpackage

// File: rtl/cml_mode_lock.sv
module cml_mode_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_mono_hw,
  input  logic cfg_skip_boot,
  input  logic cfg_color_cart,
  input  logic mode_wr,
  input  logic mode_sel,
  input  logic boot_end_wr,
  output logic compat_q,
  output logic written_q,
  output logic boot_done_q,
  output logic boot_rom_on_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (cfg_skip_boot) begin
        written_q     <= 1'b1;
        compat_q      <= cfg_mono_hw | ~cfg_color_cart;
        boot_done_q   <= 1'b1;
        boot_rom_on_q <= 1'b0;
      end else if (cfg_mono_hw) begin
        written_q     <= 1'b1;
        compat_q      <= 1'b1;
        boot_done_q   <= 1'b1;
        boot_rom_on_q <= 1'b1;
      end else begin
        written_q     <= 1'b0;
        compat_q      <= 1'b0;
        boot_done_q   <= 1'b0;
        boot_rom_on_q <= 1'b1;
      end
    end else begin
      if (mode_wr && !written_q) begin
        written_q <= 1'b1;
        compat_q  <= mode_sel;
      end
      if (boot_end_wr) begin
        boot_done_q   <= 1'b1;
        boot_rom_on_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cml_scratch_bank.sv
module cml_scratch_bank #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8,
  parameter logic [N*W-1:0] MASKS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wr_en,
  input  logic [W-1:0] wdata,
  output logic [N*W-1:0] stored,
  output logic [N*W-1:0] view
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam logic [W-1:0] M = MASKS[i*W +: W];
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (wr_en[i]) q <= wdata & M;
    end
    assign stored[i*W +: W] = q;
    assign view[i*W +: W]   = (q & M) | ~M;
  end
endmodule

// File: rtl/cml_read_mux.sv
module cml_read_mux #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] view,
  output logic [W-1:0]   rdata
);
  always_comb begin
    rdata = '1;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) rdata = view[i*W +: W];
    end
  end
endmodule

// File: rtl/cml_lock_top.sv
module cml_lock_top
  import cml_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_mono_hw,
  input  logic                    cfg_skip_boot,
  input  logic                    cfg_color_cart,
  input  logic                    io_wr,
  input  logic [ADDR_W-1:0]       io_addr,
  input  logic [DATA_W-1:0]       io_wdata,
  output logic [DATA_W-1:0]       io_rdata,
  output logic                    color_mode_o,
  output logic                    boot_rom_on_o,
  output logic [SCR_N*DATA_W-1:0] scratch_o
);
  logic compat, written, boot_done;
  logic [SCR_N-1:0] scr_hit, scr_ok, scr_sel, scr_wr;
  logic [SCR_N*DATA_W-1:0] scr_view;

  assign color_mode_o = ~compat | ~boot_done;

  cml_mode_lock u_lock (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mono_hw   (cfg_mono_hw),
    .cfg_skip_boot (cfg_skip_boot),
    .cfg_color_cart(cfg_color_cart),
    .mode_wr       (io_wr && io_addr == OFS_MODE && color_mode_o),
    .mode_sel      (io_wdata[MODE_SEL_BIT]),
    .boot_end_wr   (io_wr && io_addr == OFS_BOOT_END),
    .compat_q      (compat),
    .written_q     (written),
    .boot_done_q   (boot_done),
    .boot_rom_on_q (boot_rom_on_o)
  );

  for (genvar i = 0; i < SCR_N; i++) begin : g_dec
    assign scr_hit[i] = (io_addr == OFS_SCR_BASE + ADDR_W'(i));
    if (SCR_COLOR_GATED[i]) begin : g_col
      assign scr_ok[i] = color_mode_o;
    end else begin : g_hw
      assign scr_ok[i] = ~cfg_mono_hw;
    end
    assign scr_sel[i] = scr_hit[i] & scr_ok[i];
    assign scr_wr[i]  = scr_sel[i] & io_wr;
  end

  cml_scratch_bank #(.N(SCR_N), .W(DATA_W), .MASKS(SCR_MASKS)) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (scr_wr),
    .wdata (io_wdata),
    .stored(scratch_o),
    .view  (scr_view)
  );

  cml_read_mux #(.N(SCR_N), .W(DATA_W)) u_rd (
    .sel  (scr_sel),
    .view (scr_view),
    .rdata(io_rdata)
  );
endmodule

// File: rtl/cml_lock_chk.sv
module cml_lock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [7:0]  io_addr,
  input logic [7:0]  io_rdata,
  input logic        color_mode_o,
  input logic        boot_rom_on_o,
  input logic [31:0] scratch_o,
  input logic        written,
  input logic        compat
);
  // R3
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (written && io_wr && io_addr == 8'h4C) |=> $stable(compat));
  // R4
  color_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(color_mode_o) |-> $past(io_wr && io_addr == 8'h50));
  // R5
  boot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 8'h50) |=> !boot_rom_on_o);
  // R5
  boot_stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_rom_on_o |=> !boot_rom_on_o);
  // R6
  scr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scratch_o[31:24] & 8'h8F) == 8'h00);
  // R7
  scr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 8'h74 && !color_mode_o) |-> io_rdata == 8'hFF);
  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 8'h4C || io_addr == 8'h50 || io_addr < 8'h40) |-> io_rdata == 8'hFF);
endmodule

bind cml_lock_top cml_lock_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_wr        (io_wr),
  .io_addr      (io_addr),
  .io_rdata     (io_rdata),
  .color_mode_o (color_mode_o),
  .boot_rom_on_o(boot_rom_on_o),
  .scratch_o    (scratch_o),
  .written      (written),
  .compat       (compat)
);

// File: tb/sim_cml_lock_top.sv
`timescale 1ns/1ps
module sim_cml_lock_top;
  logic clk = 0, rst_n = 0;
  logic cfg_mono_hw = 0, cfg_skip_boot = 0, cfg_color_cart = 0;
  logic io_wr = 0;
  logic [7:0] io_addr = 0, io_wdata = 0, io_rdata;
  logic color_mode_o, boot_rom_on_o;
  logic [31:0] scratch_o;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cml_lock_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mono_hw(cfg_mono_hw),
    .cfg_skip_boot(cfg_skip_boot), .cfg_color_cart(cfg_color_cart),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .color_mode_o(color_mode_o),
    .boot_rom_on_o(boot_rom_on_o), .scratch_o(scratch_o)
  );

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mono, skip, ccart);
    @(negedge clk);
    rst_n = 0; io_wr = 0;
    cfg_mono_hw = mono; cfg_skip_boot = skip; cfg_color_cart = ccart;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [7:0] a, d);
    @(negedge clk);
    io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, exp);
    io_addr = a;
    #1;
    check(tag, {24'd0, io_rdata}, {24'd0, exp});
  endtask

  task automatic t_reset_state;
    do_reset(0, 0, 1);
    check("R1 color", color_mode_o, 1);
    check("R1 bootrom", boot_rom_on_o, 1);
    check("R1 scratch", scratch_o, 32'h0);
    rd_check("R6 read 0x75 reset", 8'h75, 8'h8F);
    rd_check("R6 read 0x72 reset", 8'h72, 8'h00);
    rd_check("R10 read 0x4C", 8'h4C, 8'hFF);
    rd_check("R5 read 0x50", 8'h50, 8'hFF);
    rd_check("R10 read 0x10", 8'h10, 8'hFF);
    rd_check("R10 read 0x76", 8'h76, 8'hFF);
  endtask

  task automatic t_compat_choice;
    do_reset(0, 0, 1);
    wr(8'h4C, 8'h04);
    check("R2 color forced during boot", color_mode_o, 1);
    wr(8'h4C, 8'h00);
    wr(8'h74, 8'h3C);
    rd_check("R7 0x74 reachable in boot", 8'h74, 8'h3C);
    wr(8'h50, 8'h00);
    check("R3 R4 compat held after boot end", color_mode_o, 0);
    check("R5 bootrom off", boot_rom_on_o, 0);
    rd_check("R7 0x74 hidden", 8'h74, 8'hFF);
    wr(8'h74, 8'h55);
    check("R7 0x74 write ignored", scratch_o[23:16], 8'h3C);
    wr(8'h73, 8'h12);
    rd_check("R7 0x73 reachable on color hw", 8'h73, 8'h12);
    wr(8'h4C, 8'h00);
    check("R3 late write ignored", color_mode_o, 0);
    wr(8'h50, 8'hAA);
    check("R5 bootrom stays off", boot_rom_on_o, 0);
  endtask

  task automatic t_color_choice;
    do_reset(0, 0, 1);
    wr(8'h4C, 8'h80);
    wr(8'h4C, 8'h04);
    wr(8'h50, 8'h5A);
    check("R2 R3 R4 color kept", color_mode_o, 1);
    check("R5 bootrom off", boot_rom_on_o, 0);
  endtask

  task automatic t_scratch;
    do_reset(0, 0, 1);
    wr(8'h75, 8'hFF);
    rd_check("R6 0x75 all ones", 8'h75, 8'hFF);
    check("R6 0x75 stored", scratch_o[31:24], 8'h70);
    wr(8'h75, 8'h8F);
    rd_check("R6 0x75 off-mask bits", 8'h75, 8'h8F);
    check("R6 0x75 stored zero", scratch_o[31:24], 8'h00);
    wr(8'h75, 8'h25);
    rd_check("R6 0x75 mixed", 8'h75, 8'hAF);
    wr(8'h72, 8'hA5);
    rd_check("R6 0x72", 8'h72, 8'hA5);
    check("R6 scratch_o index0", scratch_o[7:0], 8'hA5);
  endtask

  task automatic t_skip;
    do_reset(0, 1, 1);
    check("R8 color cart color", color_mode_o, 1);
    check("R8 bootrom off", boot_rom_on_o, 0);
    wr(8'h4C, 8'h04);
    check("R8 lock prewritten", color_mode_o, 1);
    do_reset(0, 1, 0);
    check("R8 mono cart compat", color_mode_o, 0);
    check("R8 bootrom off mono", boot_rom_on_o, 0);
    do_reset(1, 1, 1);
    check("R8 mono hw compat", color_mode_o, 0);
  endtask

  task automatic t_mono_hw;
    do_reset(1, 0, 1);
    check("R9 color off", color_mode_o, 0);
    check("R9 bootrom on", boot_rom_on_o, 1);
    rd_check("R7 0x72 hidden on mono hw", 8'h72, 8'hFF);
    wr(8'h72, 8'h33);
    check("R7 0x72 write ignored", scratch_o[7:0], 8'h00);
    wr(8'h50, 8'h01);
    check("R9 bootrom off after end", boot_rom_on_o, 0);
    check("R9 compat stays", color_mode_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_compat_choice();
    t_color_choice();
    t_scratch();
    t_skip();
    t_mono_hw();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule